// File: doc/BRIEF.md
# ADC Channel Output Formatter

This block prepares the sample stream of one converter channel for a 16-bit output lane that only transmits. Each cycle it may receive a 14-bit two's-complement sample with a valid strobe. A 2-bit mode field and a 4-bit decimation factor come from the channel's control settings. The block produces a registered 16-bit word and a one-cycle valid flag.

The mode selects what goes out on the lane. The lane can be silent. It can carry a free-running 16-bit test count, which is useful for checking a link end to end. It can also carry the converter sample with its sign widened to 16 bits. A decimator drops words so that only one word in every N+1 eligible words reaches the lane. Any change to the mode or to the factor restarts the decimator, so the first valid input after a change is always sent.

Top module: `adc_lane_formatter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `lane_valid` is 0 and `lane_word` is 0x0000. The test count starts at 0 after reset.
- R2: With `lane_mode` = 2'b00 the lane is disabled. No strobe produces a `lane_valid` pulse.
- R3: The value `lane_mode` = 2'b11 is reserved and acts exactly like 2'b00: no words are sent.
- R4: The test count rises by one on every cycle in which `smp_valid` is 1, whatever the mode. With `lane_mode` = 2'b01, each sent word is the count value held before that strobe's increment.
- R5: The test count wraps from 0xFFFF to 0x0000.
- R6: With `lane_mode` = 2'b10, the sent word is the sample with bit 13 copied into bits 14 and 15, and bits 13..0 passed through unchanged.
- R7: A word accepted in cycle t gives `lane_valid` = 1 at the clock edge that ends cycle t, and for that one cycle only. When no word is sent, `lane_valid` is 0.
- R8: With `lane_decim` = N, the lane sends the first eligible word and then every (N+1)-th eligible word. An eligible word is a strobe in mode 01 or 10. Strobes in other modes do not move the decimation phase.
- R9: With `lane_decim` = 0, every eligible word is sent.
- R10: A cycle in which `lane_mode` or `lane_decim` differs from its value in the previous cycle restarts the decimation phase. An eligible strobe in that cycle, or the first one after it, is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Two's-complement converter sample |
| lane_mode | input | 2 | 00 off, 01 test count, 10 sample, 11 reserved (off) |
| lane_decim | input | 4 | Decimation factor N: send one word in N+1 |
| lane_word | output | 16 | Registered output word |
| lane_valid | output | 1 | Output word valid, one cycle per word |

## Verification
The properties assume that `lane_mode` and `lane_decim` are stable except when they are deliberately changed. They also assume the strobe is sampled synchronously, so a configuration change and a strobe in the same cycle count as one event. The stimulus changes settings only at the falling clock edge, together with the strobe. It then runs a burst of cycles under each setting so that the restart rule and the steady decimation phase are both exercised. Sample values cover both extremes of the 14-bit range, zero, minus one and random values. Gaps without a strobe are inserted so that the decimator is seen to hold its phase while inputs are idle.

// File: rtl/lane_fmt_pkg.sv
package lane_fmt_pkg;
  localparam int SMP_W  = 14;
  localparam int WORD_W = 16;
  localparam int DEC_W  = 4;

  typedef enum logic [1:0] {
    LANE_OFF    = 2'b00,
    LANE_COUNT  = 2'b01,
    LANE_SAMPLE = 2'b10,
    LANE_RSVD   = 2'b11
  } lane_mode_e;

  // Copy the sign bit upward to fill the lane word.
  function automatic logic [WORD_W-1:0] widen(input logic [SMP_W-1:0] s);
    return {{(WORD_W-SMP_W){s[SMP_W-1]}}, s};
  endfunction

  // Next decimation phase after a word is taken at phase cur.
  function automatic logic [DEC_W-1:0] phase_step(input logic [DEC_W-1:0] cur,
                                                   input logic [DEC_W-1:0] n);
    return (cur == n) ? '0 : cur + 1'b1;
  endfunction

  function automatic logic mode_sends(input logic [1:0] m);
    return (m == LANE_COUNT) || (m == LANE_SAMPLE);
  endfunction
endpackage

// File: rtl/lane_test_counter.sv
module lane_test_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/lane_decimator.sv
module lane_decimator
  import lane_fmt_pkg::*;
#(
  parameter int DW = DEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] factor,
  input  logic          in_fire,
  output logic          cfg_change,
  output logic          emit
);
  logic [1:0]    mode_q;
  logic [DW-1:0] factor_q;
  logic [DW-1:0] phase_q;
  logic [DW-1:0] phase_eff;

  always_comb begin
    cfg_change = (mode != mode_q) || (factor != factor_q);
    phase_eff  = cfg_change ? '0 : phase_q;
    emit       = in_fire && (phase_eff == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= LANE_OFF;
      factor_q <= '0;
      phase_q  <= '0;
    end else begin
      mode_q   <= mode;
      factor_q <= factor;
      phase_q  <= in_fire ? phase_step(phase_eff, factor) : phase_eff;
    end
  end
endmodule

// File: rtl/lane_word_select.sv
module lane_word_select
  import lane_fmt_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int OW = WORD_W
) (
  input  logic [1:0]    mode,
  input  logic [SW-1:0] smp,
  input  logic [OW-1:0] count,
  output logic [OW-1:0] word
);
  always_comb begin
    unique case (mode)
      LANE_COUNT:  word = count;
      LANE_SAMPLE: word = widen(smp);
      default:     word = '0;
    endcase
  end
endmodule

// File: rtl/adc_lane_formatter.sv
module adc_lane_formatter
  import lane_fmt_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int OW = WORD_W,
  parameter int DW = DEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  input  logic [1:0]    lane_mode,
  input  logic [DW-1:0] lane_decim,
  output logic [OW-1:0] lane_word,
  output logic          lane_valid
);
  logic          fire_in;
  logic          cfg_change;
  logic          emit;
  logic [OW-1:0] test_count;
  logic [OW-1:0] sel_word;

  assign fire_in = smp_valid && mode_sends(lane_mode);

  lane_test_counter #(.W(OW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(smp_valid), .count(test_count)
  );

  lane_decimator #(.DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode(lane_mode), .factor(lane_decim),
    .in_fire(fire_in), .cfg_change(cfg_change), .emit(emit)
  );

  lane_word_select #(.SW(SW), .OW(OW)) u_sel (
    .mode(lane_mode), .smp(smp_data), .count(test_count), .word(sel_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_word  <= '0;
      lane_valid <= 1'b0;
    end else begin
      lane_valid <= emit;
      if (emit) lane_word <= sel_word;
    end
  end
endmodule

// File: rtl/lane_fmt_checker.sv
module lane_fmt_checker #(
  parameter int SW = 14,
  parameter int OW = 16,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [SW-1:0] smp_data,
  input logic [1:0]    lane_mode,
  input logic [DW-1:0] lane_decim,
  input logic [OW-1:0] lane_word,
  input logic          lane_valid,
  input logic          fire_in,
  input logic          cfg_change,
  input logic [OW-1:0] test_count
);
  // R2
  off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'b00) |=> !lane_valid);

  // R3
  rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode == 2'b11) |=> !lane_valid);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid |-> $past(fire_in));

  // R6
  widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && lane_mode == 2'b10 && lane_decim == '0) |=>
      (lane_valid && lane_word == {{(OW-SW){$past(smp_data[SW-1])}}, $past(smp_data)}));

  // R9
  no_decim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && lane_decim == '0) |=> lane_valid);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && cfg_change) |=> lane_valid);

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && test_count == '1) |=> (test_count == '0));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (test_count == $past(test_count) + 1'b1));
endmodule

bind adc_lane_formatter lane_fmt_checker #(.SW(SW), .OW(OW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .lane_mode(lane_mode), .lane_decim(lane_decim), .lane_word(lane_word),
  .lane_valid(lane_valid), .fire_in(fire_in), .cfg_change(cfg_change),
  .test_count(test_count)
);

// File: tb/adc_lane_formatter_test.sv
`timescale 1ns/1ps
module adc_lane_formatter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [13:0] smp_data = '0;
  logic [1:0]  lane_mode = 2'b00;
  logic [3:0]  lane_decim = '0;
  logic [15:0] lane_word;
  logic        lane_valid;

  always #2 clk = ~clk;

  adc_lane_formatter uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .lane_mode(lane_mode), .lane_decim(lane_decim),
    .lane_word(lane_word), .lane_valid(lane_valid)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  string       idle_tag = "R1";
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  // reference state
  logic [15:0] m_cnt = '0;
  logic [3:0]  m_phase = '0;
  logic [1:0]  m_mode = 2'b00;
  logic [3:0]  m_decim = '0;

  task automatic drive(input bit v, input logic [13:0] d, input logic [1:0] m,
                       input logic [3:0] n, input string tag);
    bit chg;
    logic [3:0] ph;
    logic [15:0] w;
    @(negedge clk);
    smp_valid = v; smp_data = d; lane_mode = m; lane_decim = n;
    chg = (m != m_mode) || (n != m_decim);
    ph  = chg ? 4'd0 : m_phase;
    if (v && (m == 2'b01 || m == 2'b10)) begin
      if (ph == 0) begin
        w = (m == 2'b01) ? m_cnt : {d[13], d[13], d};
        exp_q.push_back(w);
        tag_q.push_back(tag);
      end
      m_phase = (ph == n) ? 4'd0 : ph + 4'd1;
    end else begin
      m_phase = ph;
    end
    if (v) m_cnt = m_cnt + 16'd1;
    m_mode = m; m_decim = n;
    idle_tag = tag;
  endtask

  // monitor: one check per cycle, sampled 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      checks++;
      if (lane_valid) begin
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL %s: unexpected word %h, expected no word", idle_tag, lane_word);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (lane_word !== e) begin
            fails++;
            $display("FAIL %s: word %h, expected %h", t, lane_word, e);
          end
        end
      end else if (exp_q.size() != 0) begin
        fails++;
        $display("FAIL %s: no word, expected %h", tag_q[0], exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state while reset is held
    checks++;
    if (lane_valid !== 1'b0 || lane_word !== 16'h0000) begin
      fails++;
      $display("FAIL R1: valid=%b word=%h, expected 0 and 0000", lane_valid, lane_word);
    end
    @(negedge clk); rst_n = 1'b1;
    mon_on = 1'b1;
    drive(0, 14'h0, 2'b00, 4'd0, "R1");

    // R2 disabled lane, strobes give nothing
    for (int i = 0; i < 6; i++) drive(1, 14'(i * 77), 2'b00, 4'd0, "R2");
    // R3 reserved mode behaves as off
    for (int i = 0; i < 6; i++) drive(1, 14'h1FFF, 2'b11, 4'd0, "R3");
    // R4 count words, count already at 12 from strobes above; R9 no decimation
    for (int i = 0; i < 8; i++) drive(1, 14'h0, 2'b01, 4'd0, "R4 R9");
    // R7 gaps: no word while strobe is low
    for (int i = 0; i < 4; i++) begin
      drive(0, 14'h0, 2'b01, 4'd0, "R7");
      drive(1, 14'h0, 2'b01, 4'd0, "R7");
    end
    // R6 sign widening at the range ends and random values
    drive(1, 14'h1FFF, 2'b10, 4'd0, "R6");
    drive(1, 14'h2000, 2'b10, 4'd0, "R6");
    drive(1, 14'h0000, 2'b10, 4'd0, "R6");
    drive(1, 14'h3FFF, 2'b10, 4'd0, "R6");
    for (int i = 0; i < 20; i++) drive(1, 14'($urandom), 2'b10, 4'd0, "R6");
    // R8 decimation by 4 with idle gaps
    for (int i = 0; i < 24; i++) drive((i % 3) != 2, 14'($urandom), 2'b10, 4'd3, "R8");
    // R8 phase holds through off mode? off mode is a config change, then R10
    for (int i = 0; i < 3; i++) drive(1, 14'h0123, 2'b00, 4'd3, "R2");
    // R10 restart on decim change, and on mode change
    for (int i = 0; i < 5; i++) drive(1, 14'($urandom), 2'b10, 4'd15, "R10");
    drive(1, 14'h0AAA, 2'b10, 4'd2, "R10");
    for (int i = 0; i < 4; i++) drive(1, 14'($urandom), 2'b10, 4'd2, "R10");
    drive(1, 14'h0555, 2'b01, 4'd2, "R10");
    drive(0, 14'h0, 2'b10, 4'd2, "R10");
    drive(1, 14'h1234, 2'b10, 4'd2, "R10");
    // R8 largest factor
    for (int i = 0; i < 40; i++) drive(1, 14'($urandom), 2'b10, 4'd15, "R8");
    // R5 wrap: run the count up to the top with the lane off
    while (m_cnt != 16'hFFFA) drive(1, 14'h0, 2'b00, 4'd0, "R2");
    for (int i = 0; i < 12; i++) drive(1, 14'h0, 2'b01, 4'd0, "R5");
    drive(0, 14'h0, 2'b00, 4'd0, "R2");
    drive(0, 14'h0, 2'b00, 4'd0, "R2");
    done = 1'b1;
    mon_on = 1'b0;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7: %0d words never sent, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule